// File: doc/BRIEF.md
# Parity-Checked Serial Character Receiver

This block receives one asynchronous serial character of fixed length from a single line that idles high. A character occupies eleven bit times: a low start bit, eight data bits sent least significant bit first, a ninth slot, and a final high stop bit. The ninth slot carries a parity bit when even or odd parity is configured. When parity is off it must be a second high stop bit, so the character length never changes. The receiver presents the eight data bits together with a one-cycle valid strobe, and it reports parity and framing errors on the same cycle as that strobe.

Bit timing comes from an external rate generator. It drives `sample_tick` high for one clock cycle `OVERSAMPLE` times per bit period. The line passes through a `SYNC_STAGES`-deep synchroniser. A control state machine then walks six named states. `IDLE` waits for a low level on a tick (transition IDLE→START). `START` re-samples at mid-bit and either proceeds (START→DATA) or treats a high level as a glitch (START→IDLE). `DATA` takes eight mid-bit samples (DATA→SLOT after the eighth). `SLOT` samples the ninth slot (SLOT→STOP). `STOP` samples the final stop bit (STOP→TAIL). `TAIL` waits half a bit so that the result appears at the end of the stop bit (TAIL→IDLE, emitting the result). The parity mode input is shared by every node on the link and must be held steady during a character.

Top module: `serial_char_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_parity_err` and `rx_frame_err` are 0 and stay 0 while the line is held high.
- R2: Data bits are received least significant bit first. The eight sampled bits appear on `rx_data` with bit 0 holding the first data bit after the start bit.
- R3: With `par_mode` = 2'b01 (even), `rx_parity_err` is raised when the number of ones in the eight data bits plus the ninth-slot bit is odd. For example, data 8'hC5 with a ninth bit of 0 is accepted.
- R4: With `par_mode` = 2'b10 (odd), `rx_parity_err` is raised when that count of ones is even. For example, data 8'hC5 with a ninth bit of 1 is accepted.
- R5: With `par_mode` = 2'b00 or 2'b11 (none), `rx_parity_err` is never raised. A low ninth slot raises `rx_frame_err`.
- R6: An even number of flipped bits among the data and parity bits of one character raises no parity error.
- R7: A start bit that is no longer low at its mid-bit sample is ignored. No strobe follows it, and the receiver waits for the next falling level.
- R8: A low final stop bit raises `rx_frame_err` in every parity mode.
- R9: `rx_valid` is a single-cycle pulse, one per received character. `rx_parity_err` and `rx_frame_err` are only ever high during such a pulse.
- R10: The strobe appears at the end of the final stop bit. It comes no earlier than the end of the character on the line, and no later than one tick interval plus the synchroniser latency and the output register delay after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial line; idles high |
| sample_tick | input | 1 | One-cycle pulse, `OVERSAMPLE` per bit period |
| par_mode | input | 2 | 00/11 none, 01 even, 10 odd |
| rx_data | output | 8 | Received data byte, held until the next strobe |
| rx_valid | output | 1 | One-cycle strobe when a character completes |
| rx_parity_err | output | 1 | Parity mismatch, valid with the strobe |
| rx_frame_err | output | 1 | Low stop-position bit, valid with the strobe |

## Verification
The byte 8'hC5 is sent with both ninth-bit values in even and in odd mode. This separates a correct parity sense from an inverted or missing one. The bytes 8'h01, 8'h80, 8'h00 and 8'hFF tell a correct bit order from a reversed one and exercise the all-zero and all-one parity counts. A byte with two flipped data bits shows that the check follows count evenness rather than the value itself. Both encodings of no-parity, with high and with low ninth slots, a low final stop bit and a short start-bit glitch separate framing faults from parity faults and show that spurious starts leave no trace.

// File: rtl/scrx_pkg.sv
package scrx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'b00,
        PAR_EVEN     = 2'b01,
        PAR_ODD      = 2'b10,
        PAR_NONE_ALT = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_SLOT,
        ST_STOP,
        ST_TAIL
    } rx_state_e;

    function automatic logic par_enabled(input logic [1:0] m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

endpackage

// File: rtl/scrx_bit_timer.sv
// Counts sample ticks; fires after a half or a full bit period.
module scrx_bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic half_sel,
    output logic fire
);
    localparam int CW   = $clog2(OVERSAMPLE + 1);
    localparam int HALF = OVERSAMPLE / 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        limit = half_sel ? CW'(HALF) : CW'(OVERSAMPLE);
        fire  = tick && !restart && (cnt == limit - CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= fire ? '0 : cnt + CW'(1);
        end
    end

    // R10: the counter never runs past the selected period
    p_cnt_in_period_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < limit);

endmodule

// File: rtl/scrx_datapath.sv
// Shift register for data bits plus captured ninth-slot and stop bits.
module scrx_datapath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              slot_en,
    input  logic              stop_en,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] data,
    output logic              parity_err,
    output logic              frame_err
);
    import scrx_pkg::*;

    logic [DATA_W-1:0] shreg;
    logic              slot_bit;
    logic              stop_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            slot_bit <= 1'b1;
            stop_bit <= 1'b1;
        end else begin
            if (clear) begin
                slot_bit <= 1'b1;
                stop_bit <= 1'b1;
            end
            if (shift_en) shreg    <= {line, shreg[DATA_W-1:1]};
            if (slot_en)  slot_bit <= line;
            if (stop_en)  stop_bit <= line;
        end
    end

    always_comb begin
        data       = shreg;
        parity_err = par_enabled(mode) &&
                     ((^shreg ^ slot_bit) != (mode == PAR_ODD));
        frame_err  = !stop_bit || (!par_enabled(mode) && !slot_bit);
    end

endmodule

// File: rtl/scrx_ctrl.sv
// Character framing state machine.
module scrx_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic fire,
    output logic restart,
    output logic half_sel,
    output logic clear,
    output logic shift_en,
    output logic slot_en,
    output logic stop_en,
    output logic emit
);
    import scrx_pkg::*;

    localparam int IW = $clog2(DATA_W + 1);

    rx_state_e     state, state_nx;
    logic [IW-1:0] bit_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_START)
                bit_idx <= '0;
            else if (shift_en)
                bit_idx <= bit_idx + IW'(1);
        end
    end

    always_comb begin
        state_nx = state;
        restart  = 1'b0;
        half_sel = 1'b0;
        clear    = 1'b0;
        shift_en = 1'b0;
        slot_en  = 1'b0;
        stop_en  = 1'b0;
        emit     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                half_sel = 1'b1;
                if (tick && !line) begin
                    restart  = 1'b1;
                    clear    = 1'b1;
                    state_nx = ST_START;
                end
            end
            ST_START: begin
                half_sel = 1'b1;
                if (fire) state_nx = line ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (fire) begin
                    shift_en = 1'b1;
                    if (bit_idx == IW'(DATA_W - 1)) state_nx = ST_SLOT;
                end
            end
            ST_SLOT: begin
                if (fire) begin
                    slot_en  = 1'b1;
                    state_nx = ST_STOP;
                end
            end
            ST_STOP: begin
                if (fire) begin
                    stop_en  = 1'b1;
                    state_nx = ST_TAIL;
                end
            end
            ST_TAIL: begin
                half_sel = 1'b1;
                if (fire) begin
                    emit     = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // R7: a high level at the start-bit midpoint returns to idle
    p_glitch_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && fire && line) |=> (state == ST_IDLE));

    // R2: exactly DATA_W data samples per character
    p_bit_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (bit_idx < IW'(DATA_W)));

    // R10: the result is produced only after the stop bit was sampled
    p_tail_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_TAIL) |-> $past(state) == ST_STOP);

endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx #(
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              sample_tick,
    input  logic [1:0]        par_mode,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_parity_err,
    output logic              rx_frame_err
);
    import scrx_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line_s;
    logic                   fire, restart, half_sel, clear;
    logic                   shift_en, slot_en, stop_en, emit;
    logic [DATA_W-1:0]      dp_data;
    logic                   dp_perr, dp_ferr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
    end
    assign line_s = sync_q[SYNC_STAGES-1];

    scrx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_tick),
        .restart  (restart),
        .half_sel (half_sel),
        .fire     (fire)
    );

    scrx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_tick),
        .line     (line_s),
        .fire     (fire),
        .restart  (restart),
        .half_sel (half_sel),
        .clear    (clear),
        .shift_en (shift_en),
        .slot_en  (slot_en),
        .stop_en  (stop_en),
        .emit     (emit)
    );

    scrx_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .line       (line_s),
        .clear      (clear),
        .shift_en   (shift_en),
        .slot_en    (slot_en),
        .stop_en    (stop_en),
        .mode       (par_mode),
        .data       (dp_data),
        .parity_err (dp_perr),
        .frame_err  (dp_ferr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data       <= '0;
            rx_valid      <= 1'b0;
            rx_parity_err <= 1'b0;
            rx_frame_err  <= 1'b0;
        end else begin
            rx_valid      <= emit;
            rx_parity_err <= emit && dp_perr;
            rx_frame_err  <= emit && dp_ferr;
            if (emit) rx_data <= dp_data;
        end
    end

    // R9: error flags only accompany a strobe
    p_err_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_parity_err || rx_frame_err) |-> rx_valid);

    // R9: the strobe lasts one cycle
    p_valid_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: no parity error when parity is switched off
    p_none_no_perr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !par_enabled($past(par_mode))) |-> !rx_parity_err);

endmodule

// File: tb/sim_serial_char_rx.sv
module sim_serial_char_rx;

    localparam int OVS  = 8;
    localparam int TDIV = 4;
    localparam int SYNC = 2;
    localparam int BITC = OVS * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       sample_tick = 1'b0;
    logic [1:0] par_mode = 2'b01;
    logic [7:0] rx_data;
    logic       rx_valid, rx_parity_err, rx_frame_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int end_cyc = 0;
    int pulses = 0;
    bit prev_valid = 1'b0;
    logic [9:0] exp_q[$];   // {data, perr, ferr}

    always #2.5 clk = ~clk;

    serial_char_rx #(.DATA_W(8), .OVERSAMPLE(OVS), .SYNC_STAGES(SYNC)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_line       (rx_line),
        .sample_tick   (sample_tick),
        .par_mode      (par_mode),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .rx_parity_err (rx_parity_err),
        .rx_frame_err  (rx_frame_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // tick generator and cycle counter
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            sample_tick = (div == 0);
            div = (div + 1) % TDIV;
        end
    end
    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // reference comparison on every clock
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (!rx_valid && (rx_parity_err || rx_frame_err))
                chk(1'b0, "R9 error without strobe", {rx_parity_err, rx_frame_err}, 0);
            if (rx_valid && prev_valid)
                chk(1'b0, "R9 strobe wider than one cycle", 2, 1);
            if (rx_valid) begin
                pulses++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected strobe", rx_data, 0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e[9:2], "R2 data byte", rx_data, e[9:2]);
                    chk(rx_parity_err == e[1], "R3 R4 R5 R6 parity flag", rx_parity_err, e[1]);
                    chk(rx_frame_err == e[0], "R5 R8 framing flag", rx_frame_err, e[0]);
                    chk((cyc - end_cyc) >= 0 && (cyc - end_cyc) <= TDIV + SYNC + 4,
                        "R10 strobe timing", cyc - end_cyc, TDIV + SYNC);
                end
            end
            prev_valid = rx_valid;
        end
    end

    task automatic line_for(input logic v, input int clocks);
        rx_line = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] m, input logic [7:0] d,
                        input logic slot, input logic stop);
        logic pen, pe, fe;
        par_mode = m;
        pen = (m == 2'b01) || (m == 2'b10);
        pe  = pen && ((($countones(d) + slot) % 2) != ((m == 2'b10) ? 1 : 0));
        fe  = !stop || (!pen && !slot);
        exp_q.push_back({d, pe, fe});
        line_for(1'b0, BITC);
        for (int i = 0; i < 8; i++) line_for(d[i], BITC);
        line_for(slot, BITC);
        line_for(stop, BITC);
        end_cyc = cyc;
        line_for(1'b1, 2 * BITC);
    endtask

    initial begin
        #400000;
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int p0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3 * BITC) @(negedge clk);
        // R1: quiet after reset with idle line
        chk(!rx_valid && !rx_parity_err && !rx_frame_err && pulses == 0,
            "R1 idle after reset", {rx_valid, rx_parity_err, rx_frame_err}, 0);

        // R3: even parity
        send(2'b01, 8'hC5, 1'b0, 1'b1);
        send(2'b01, 8'hC5, 1'b1, 1'b1);
        send(2'b01, 8'h00, 1'b0, 1'b1);
        send(2'b01, 8'hFF, 1'b1, 1'b1);
        // R4: odd parity
        send(2'b10, 8'hC5, 1'b1, 1'b1);
        send(2'b10, 8'hC5, 1'b0, 1'b1);
        // R2: bit order
        send(2'b10, 8'h01, 1'b0, 1'b1);
        send(2'b10, 8'h80, 1'b0, 1'b1);
        // R6: two flipped data bits in 8'hC5 (-> 8'hD7), even parity bit unchanged
        send(2'b01, 8'hD7, 1'b0, 1'b1);
        // R6: one data bit and the parity bit flipped
        send(2'b10, 8'hC4, 1'b0, 1'b1);
        // R5: no parity, both encodings
        send(2'b00, 8'h5A, 1'b1, 1'b1);
        send(2'b00, 8'h5A, 1'b0, 1'b1);
        send(2'b11, 8'h3C, 1'b1, 1'b1);
        send(2'b11, 8'h3C, 1'b0, 1'b1);
        // R8: low final stop bit
        send(2'b01, 8'hC5, 1'b0, 1'b0);
        send(2'b00, 8'hA5, 1'b1, 1'b0);

        // R7: short start glitch
        p0 = pulses;
        line_for(1'b0, 2 * TDIV);
        line_for(1'b1, 14 * BITC);
        chk(pulses == p0, "R7 glitch produced no strobe", pulses - p0, 0);
        send(2'b01, 8'h96, 1'b0, 1'b1);

        chk(exp_q.size() == 0, "R9 one strobe per character", exp_q.size(), 0);
        finish_run();
    end

endmodule